// File: doc/BRIEF.md
# Serial Audio Transmitter with Time-Division Slots

This block turns a pair of parallel 24-bit samples (left and right) into a serial bit stream on one data pin. It has four framings: left justified, I2S, right justified, and a time-division mode. In the time-division mode several transmitters share one data line, and each one drives only inside its own 64-bit slot. A 2-bit format code selects the framing and a 2-bit length code selects how many of the top sample bits are sent. Dither and rate conversion are not part of this block. The sample word is sent as it is given.

All logic runs on one fast system clock, and the audio clocks are sampled as levels. In slave mode the bit clock and word clock come from outside, and data is updated after each falling bit-clock edge. In master mode the block makes both clocks from a sampled reference clock:

- For the stereo framings it divides the reference clock.
- In time-division mode the bit clock follows the reference clock one for one.

A one-cycle `load_o` pulse shows the moment a new sample pair is captured.

Top module: `audio_serial_tx`

## Requirements
- R1: After reset, every output is low. Until the first frame start is seen, `sdata_o` and `sdata_oe` stay low.
- R2: Format code 00 (left justified): a word clock high marks the left half. The MSB is sent on the first bit of each half, which is the bit whose falling edge carries the word-clock change.
- R3: Format code 01 (I2S): a word clock low marks the left half. The MSB is sent one bit after the word-clock change, and that first bit carries 0.
- R4: Format code 11 (right justified): the LSB falls on the last bit of each half. The half length is measured from the previous half, which must be at least the word length. The bits ahead of the word are 0.
- R5: Length code 00 gives 24 bits, 01 gives 20, 10 gives 18 and 11 gives 16. Only the top bits of the 24-bit sample are sent, and every bit after the word within its field is 0.
- R6: Format code 10 (time-division): a rising word clock starts the frame, and the falling word clock does not restart it. The frame is split into 64-bit slots numbered from 0. Slot `slot_idx` carries left in its first 32 bits and right in its next 32 bits, each MSB first.
- R7: In time-division mode, outside the block's own slot, `sdata_o` and `sdata_oe` are low. In the other framings `sdata_oe` is high once synchronised.
- R8: The sample pair is captured at each frame start, and `load_o` pulses once at that moment. Changes on `left_i` and `right_i` during the frame have no effect on the bits sent.
- R9: `sdata_o` changes only after a falling bit-clock edge, so it is stable at the following rising edge.
- R10: In master mode with a stereo framing, the bit clock period is 2, 4 or 8 reference periods for `ref_ratio` 00, 01 or 1x. A frame holds 64 bits, and the word clock holds each level for 32 bits. The word clock is high first for codes 00 and 11, and low first for code 01.
- R11: In master mode with time-division, the bit clock runs at the reference clock rate. A frame holds 64×(`dev_last`+1) bits, and the word clock is high for exactly the first 32 bits.
- R12: In slave mode, `bclk_o` and `lrck_o` are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all audio clocks are sampled with it |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | 1: generate the bit and word clocks; 0: take them from the pins |
| fmt | input | 2 | Framing code (see R2, R3, R4, R6) |
| wlen | input | 2 | Word length code (see R5) |
| ref_ratio | input | 2 | Master stereo divider code (see R10) |
| dev_last | input | SW (2) | Number of devices on the shared line minus one (master time-division) |
| slot_idx | input | SW (2) | Own slot number in time-division mode |
| ref_clk | input | 1 | Reference clock level |
| bclk_i | input | 1 | Bit clock in slave mode |
| lrck_i | input | 1 | Word clock in slave mode |
| left_i | input | DW (24) | Left sample |
| right_i | input | DW (24) | Right sample |
| bclk_o | output | 1 | Generated bit clock (master) |
| lrck_o | output | 1 | Generated word clock (master) |
| sdata_o | output | 1 | Serial data |
| sdata_oe | output | 1 | Drive enable for the shared data line |
| load_o | output | 1 | One-cycle pulse when a sample pair is captured |

## Verification
The bench builds the block with its default values: four devices, which gives 2-bit slot and device fields, and 24-bit samples. These values make a four-device time-division frame of 256 bits reachable, along with slot indices at both ends of the range. They also push the bit counter far enough to show that a falling word clock mid-frame is ignored. Right-justified half lengths from 24 to 64 bits and all three master dividers fit in the same build, so word lengths that exactly fill a half are covered as well.

// File: rtl/audio_serial_tx.sv
module audio_serial_tx #(
  parameter int DEV_MAX = 4,
  parameter int DW = 24,
  localparam int SW = (DEV_MAX > 1) ? $clog2(DEV_MAX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic [1:0]    fmt,
  input  logic [1:0]    wlen,
  input  logic [1:0]    ref_ratio,
  input  logic [SW-1:0] dev_last,
  input  logic [SW-1:0] slot_idx,
  input  logic          ref_clk,
  input  logic          bclk_i,
  input  logic          lrck_i,
  input  logic [DW-1:0] left_i,
  input  logic [DW-1:0] right_i,
  output logic          bclk_o,
  output logic          lrck_o,
  output logic          sdata_o,
  output logic          sdata_oe,
  output logic          load_o
);
  localparam int IW = $clog2(64 * DEV_MAX) + 1;
  localparam int HW = IW - 6;
  localparam logic [1:0] F_LJ = 2'b00, F_I2S = 2'b01, F_TDM = 2'b10, F_RJ = 2'b11;

  logic          ref_q, bclk_q, m_bclk, m_lrck, lr_prev, synced;
  logic [2:0]    div_cnt, div_m1, div_nx;
  logic [IW-1:0] m_cnt, m_cnt_n, frame_m1, idx, idx_n, hlen;
  logic [DW-1:0] hold_l, hold_r, word, shl;
  logic [5:0]    wl;
  logic [IW:0]   pos, wle, idxe, he;
  logic          tdm, evt, m_lr_n, lr_now, start_lvl, start, lr_edge, own, is_left, ok;

  always_comb
    case (ref_ratio)
      2'b00:   div_m1 = 3'd1;
      2'b01:   div_m1 = 3'd3;
      default: div_m1 = 3'd7;
    endcase

  always_comb
    case (wlen)
      2'b00:   wl = 6'd24;
      2'b01:   wl = 6'd20;
      2'b10:   wl = 6'd18;
      default: wl = 6'd16;
    endcase

  assign tdm       = fmt == F_TDM;
  assign div_nx    = (div_cnt >= div_m1) ? 3'd0 : div_cnt + 3'd1;
  assign frame_m1  = tdm ? IW'((int'(dev_last) + 1) * 64 - 1) : IW'(63);
  assign evt       = master ? (tdm ? (~ref_clk & ref_q) : (ref_clk & ~ref_q & (div_nx == 3'd0)))
                            : (bclk_q & ~bclk_i);
  assign m_cnt_n   = (m_cnt >= frame_m1) ? '0 : m_cnt + 1'b1;
  assign m_lr_n    = (fmt == F_I2S) ? (m_cnt_n >= IW'(32)) : (m_cnt_n < IW'(32));
  assign lr_now    = master ? m_lr_n : lrck_i;
  assign start_lvl = fmt != F_I2S;
  assign start     = (lr_now != lr_prev) && (lr_now == start_lvl);
  assign lr_edge   = tdm ? start : (lr_now != lr_prev);
  assign idx_n     = lr_edge ? '0 : (&idx ? idx : idx + 1'b1);
  assign own       = idx_n[IW-1:6] == HW'(slot_idx);
  assign is_left   = tdm ? ~idx_n[5] : (lr_now == start_lvl);
  assign word      = is_left ? (start ? left_i : hold_l) : (start ? right_i : hold_r);
  assign wle       = (IW+1)'(wl);
  assign idxe      = {1'b0, idx_n};
  assign he        = {1'b0, hlen};

  always_comb begin
    pos = idxe;
    ok  = 1'b0;
    case (fmt)
      F_LJ:  ok = idxe < wle;
      F_I2S: begin pos = idxe - 1'b1; ok = (idx_n != '0) && (idxe <= wle); end
      F_TDM: begin pos = (IW+1)'(idx_n[4:0]); ok = own && (pos < wle); end
      F_RJ:  begin pos = idxe + wle - he; ok = (idxe < he) && (idxe + wle >= he); end
      default: ok = 1'b0;
    endcase
  end

  assign shl    = word << pos;
  assign bclk_o = master & m_bclk;
  assign lrck_o = master & m_lrck;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0; bclk_q <= 1'b0; m_bclk <= 1'b0; m_lrck <= 1'b0;
      div_cnt <= '0; m_cnt <= '1; lr_prev <= 1'b0; synced <= 1'b0;
      idx <= '1; hlen <= IW'(32); hold_l <= '0; hold_r <= '0;
      sdata_o <= 1'b0; sdata_oe <= 1'b0; load_o <= 1'b0;
    end else begin
      ref_q  <= ref_clk;
      bclk_q <= bclk_i;
      load_o <= evt & start;
      if (master) begin
        if (tdm) m_bclk <= ref_clk;
        else if (ref_clk & ~ref_q) begin
          div_cnt <= div_nx;
          m_bclk  <= div_nx > (div_m1 >> 1);
        end
      end
      if (evt) begin
        if (master) begin
          m_cnt  <= m_cnt_n;
          m_lrck <= m_lr_n;
        end
        lr_prev <= lr_now;
        idx     <= idx_n;
        if (lr_edge && !tdm) hlen <= &idx ? idx : idx + 1'b1;
        if (start) begin
          synced <= 1'b1;
          hold_l <= left_i;
          hold_r <= right_i;
        end
        sdata_o  <= (synced | start) & ok & shl[DW-1];
        sdata_oe <= (synced | start) & (~tdm | own);
      end
    end
  end

  logic          bo_q, lo_q, chk_seen;
  logic [IW-1:0] chk_n;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bo_q <= 1'b0; lo_q <= 1'b0; chk_seen <= 1'b0; chk_n <= '0;
    end else begin
      bo_q <= bclk_o;
      lo_q <= lrck_o;
      if (lrck_o != lo_q) begin
        chk_n    <= '0;
        chk_seen <= 1'b1;
      end else if (bo_q & ~bclk_o) chk_n <= chk_n + 1'b1;
    end
  end

  // R10 stereo half width and R11 time-division pulse width
  p_wclk_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (master && chk_seen && (lrck_o != lo_q) && (!tdm || !lrck_o)) |-> (chk_n == IW'(31)));
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata_o);
  p_load_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);
  p_data_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !$stable(sdata_o)) |-> $fell(bclk_o));
endmodule

// File: tb/sim_audio_serial_tx.sv
module sim_audio_serial_tx;
  logic clk = 1'b0, rst_n = 1'b0, master = 1'b0, ref_clk = 1'b0, bclk_i = 1'b0, lrck_i = 1'b0;
  logic [1:0] fmt = 2'b00, wlen = 2'b00, ref_ratio = 2'b00, dev_last = 2'b00, slot_idx = 2'b00;
  logic [23:0] left_i = 24'h0, right_i = 24'h0;
  logic bclk_o, lrck_o, sdata_o, sdata_oe, load_o;

  int checks = 0, errors = 0, cyc = 0, frames = 0, k = 0, last_rise = 0, rcnt = 0;
  int cfg_fmt = 0, cfg_L = 24, cfg_H = 32, cfg_fbits = 64, cfg_slot = 0, cfg_div = 2;
  bit mon_en = 0, ref_en = 0, bc_prev = 0, lr_prv = 0, done = 0;
  logic [23:0] lat_l = 0, lat_r = 0, fl = 0, fr = 0;

  always #2 clk = ~clk;

  audio_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .master(master), .fmt(fmt), .wlen(wlen), .ref_ratio(ref_ratio),
    .dev_last(dev_last), .slot_idx(slot_idx), .ref_clk(ref_clk), .bclk_i(bclk_i), .lrck_i(lrck_i),
    .left_i(left_i), .right_i(right_i), .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o),
    .sdata_oe(sdata_oe), .load_o(load_o));

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (k=%0d frame=%0d)", tag, act, exp, k, frames);
    end
  endtask

  function automatic int wl_of(input int code);
    case (code)
      0: return 24;
      1: return 20;
      2: return 18;
      default: return 16;
    endcase
  endfunction

  function automatic logic [1:0] expect_bit(input int f, input int L, input int H, input int kk,
                                            input logic [23:0] l, input logic [23:0] r, input int slot);
    int off, b, p;
    logic [23:0] w;
    if (f == 2) begin
      off = kk % 64;
      b = off % 32;
      w = (off >= 32) ? r : l;
      if (kk / 64 != slot) return 2'b00;
      return {1'b1, (b < L) ? w[23-b] : 1'b0};
    end
    p = (kk >= H) ? kk - H : kk;
    w = (kk >= H) ? r : l;
    case (f)
      0: return {1'b1, (p < L) ? w[23-p] : 1'b0};
      1: return {1'b1, (p >= 1 && p <= L) ? w[24-p] : 1'b0};
      default: return {1'b1, (p >= H - L) ? w[23-(p-H+L)] : 1'b0};
    endcase
  endfunction

  function automatic string tag_of(input int f);
    case (f)
      0: return "R2/R5/R8/R9";
      1: return "R3/R5/R8/R9";
      2: return "R6/R7/R5/R8";
      default: return "R4/R5/R8/R9";
    endcase
  endfunction

  always @(negedge clk) if (ref_en) begin
    rcnt++;
    if (rcnt == 2) begin rcnt = 0; ref_clk = ~ref_clk; end
  end

  always @(negedge clk) begin
    logic bc, lr, st;
    logic [1:0] e;
    bit lr_exp;
    cyc++;
    if (load_o) begin
      lat_l = left_i; lat_r = right_i;
      left_i = 24'($urandom); right_i = 24'($urandom);
    end
    bc = master ? bclk_o : bclk_i;
    lr = master ? lrck_o : lrck_i;
    if (mon_en && bc && !bc_prev) begin
      st = (cfg_fmt == 2) ? (lr && !lr_prv) : ((lr != lr_prv) && (lr == (cfg_fmt != 1)));
      if (st) begin
        if (master && frames >= 2)
          chk(k + 1 == cfg_fbits, (cfg_fmt == 2) ? "R11 frame bits" : "R10 frame bits", k + 1, cfg_fbits);
        frames++; k = 0; fl = lat_l; fr = lat_r;
      end else k++;
      if (frames == 0) chk({sdata_oe, sdata_o} == 2'b00, "R1 unsynced", {sdata_oe, sdata_o}, 0);
      else if (frames >= 2) begin
        e = expect_bit(cfg_fmt, cfg_L, cfg_H, k, fl, fr, cfg_slot);
        chk({sdata_oe, sdata_o} == e, tag_of(cfg_fmt), {sdata_oe, sdata_o}, e);
        if (master) begin
          lr_exp = (cfg_fmt == 1) ? (k >= 32) : (k < 32);
          chk(lr == lr_exp, (cfg_fmt == 2) ? "R11 word clock" : "R10 word clock", lr, lr_exp);
          chk(cyc - last_rise == ((cfg_fmt == 2) ? 4 : 4 * cfg_div),
              (cfg_fmt == 2) ? "R11 bit period" : "R10 bit period", cyc - last_rise,
              (cfg_fmt == 2) ? 4 : 4 * cfg_div);
        end
      end
      lr_prv = lr;
      last_rise = cyc;
    end
    bc_prev = bc;
  end

  task automatic bitclk(input logic lr);
    @(posedge clk); #1 bclk_i = 1'b0; lrck_i = lr;
    repeat (3) @(posedge clk);
    #1 bclk_i = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic run_cfg(input bit m, input int f, input int wc, input int H, input int ndev,
                         input int slot, input int ratio);
    logic idle, lvl;
    mon_en = 0; ref_en = 0; rst_n = 0;
    master = m; fmt = 2'(f); wlen = 2'(wc); ref_ratio = 2'(ratio);
    dev_last = 2'(ndev - 1); slot_idx = 2'(slot);
    cfg_fmt = f; cfg_L = wl_of(wc); cfg_slot = slot;
    cfg_div = (ratio == 0) ? 2 : (ratio == 1) ? 4 : 8;
    cfg_H = m ? 32 : H;
    cfg_fbits = (f == 2) ? 64 * ndev : 64;
    lvl = (f != 1);
    idle = (f == 2) ? 1'b0 : ~lvl;
    bclk_i = 1'b0; lrck_i = m ? 1'b0 : idle; ref_clk = 1'b0; rcnt = 0;
    frames = 0; k = 0; bc_prev = 0; lr_prv = m ? 1'b0 : idle;
    repeat (4) @(posedge clk);
    #1 rst_n = 1; mon_en = 1;
    if (m) begin
      ref_en = 1;
      while (frames < 5) @(posedge clk);
    end else begin
      for (int i = 0; i < 8; i++) bitclk(idle);
      for (int fr_i = 0; fr_i < 4; fr_i++)
        for (int j = 0; j < ((f == 2) ? 64 * ndev : 2 * H); j++)
          bitclk((f == 2) ? (j < 32) : ((j < H) ? lvl : ~lvl));
      chk(bclk_o == 1'b0 && lrck_o == 1'b0, "R12 slave clocks idle", {bclk_o, lrck_o}, 0);
    end
    mon_en = 0; ref_en = 0;
  endtask

  initial begin
    void'($urandom(20240611));
    repeat (3) @(posedge clk);
    #1;
    chk({bclk_o, lrck_o, sdata_o, sdata_oe, load_o} == 5'b0, "R1 reset state",
        {bclk_o, lrck_o, sdata_o, sdata_oe, load_o}, 0);
    run_cfg(0, 0, 0, 32, 1, 0, 0);
    run_cfg(0, 1, 1, 32, 1, 0, 0);
    run_cfg(0, 3, 0, 24, 1, 0, 0);
    run_cfg(0, 3, 2, 64, 1, 0, 0);
    run_cfg(0, 2, 0, 0, 4, 2, 0);
    run_cfg(0, 2, 3, 0, 1, 0, 0);
    run_cfg(0, 2, 1, 0, 4, 3, 0);
    run_cfg(1, 0, 0, 0, 1, 0, 0);
    run_cfg(1, 1, 2, 0, 1, 0, 1);
    run_cfg(1, 3, 0, 0, 1, 0, 2);
    run_cfg(1, 2, 1, 0, 3, 1, 0);
    for (int n = 0; n < 6; n++) begin
      int f, nd, hsel;
      f = int'($urandom % 4);
      nd = 1 + int'($urandom % 4);
      hsel = int'($urandom % 4);
      run_cfg(0, f, int'($urandom % 4), (hsel == 0) ? 24 : (hsel == 1) ? 32 : (hsel == 2) ? 48 : 64,
              nd, int'($urandom % nd), 0);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule